// File: doc/BRIEF.md
# Strap-Selected Watchdog Reset Timer

This block watches for proof of life from software and pulls a system reset when that proof stops arriving. Software keeps the timer quiet by writing to one fixed I/O port. The block ignores the data of that write and only looks at the address. If no such write arrives within the timeout interval, the block drives a reset pulse of fixed length. After the pulse it reloads and starts counting again.

A strap pin sets how the timer starts. With the strap high, the timer is armed whenever the block is out of reset, and software cannot turn it off. With the strap low, the timer comes up idle. It only begins counting once software writes an arm command to a control port next to the service port, and software can disarm it again. The strap is expected to be static and is only changed while reset is held.

The interval is set in milliseconds. The number of clocks comes from the clock frequency parameter through a per-millisecond prescaler. This lets a small configuration shrink the 1.5 s default window to a few hundred cycles.

Top module: `strap_watchdog`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `wdt_rst_out` is low and the software arm flag is cleared. This holds even if a pulse was in progress.
- R2: With `mode_always` = 1, the timer counts from the last clock edge at which reset was sampled high. With no service write, `wdt_rst_out` rises exactly LIMIT edges later, where LIMIT = (CLK_HZ/1000) × TIMEOUT_MS clocks.
- R3: An I/O write to address SVC_ADDR (default 0x1EF), with any data, restarts the count. The next pulse rises LIMIT edges after the edge that sampled the write.
- R4: With `mode_always` = 0, the timer is idle after reset. No pulse occurs until an arm command is written, and service writes while idle have no effect.
- R5: A write to CTRL_ADDR (default 0x1EE) with data bit 0 = 1 arms the timer in the software-controlled mode and restarts the count. The first pulse rises LIMIT edges after that write. A repeated arm write also restarts the count.
- R6: A write to CTRL_ADDR with data bit 0 = 0 disarms the timer and clears the count. The other data bits have no effect. A later arm write then times out a full LIMIT edges after it.
- R7: With `mode_always` = 1, writes to CTRL_ADDR change nothing: they neither stop the timer nor restart it.
- R8: A pulse lasts exactly PULSE_CLKS cycles. In the always-armed mode the next pulse rises LIMIT edges after the edge on which the pulse falls. In the software-controlled mode the timer returns to idle after the pulse.
- R9: A service write sampled on the same edge as the terminal count wins: no pulse is produced, and a fresh full interval starts.
- R10: Writes to any other address, and any write during a pulse, are ignored. A pulse is neither shortened nor re-armed by them.
- R11: The interval length is derived only from CLK_HZ and TIMEOUT_MS: one millisecond tick every CLK_HZ/1000 clocks, and TIMEOUT_MS ticks per interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W | I/O write address |
| io_wdata | input | DATA_W | I/O write data |
| mode_always | input | 1 | Strap: 1 = always armed, 0 = software-controlled |
| wdt_rst_out | output | 1 | Reset pulse, high for PULSE_CLKS cycles on timeout |

## Verification
The assertions check several rules on every cycle:
- An expiry happens exactly one clock short of LIMIT armed cycles after the last restart.
- The millisecond counter never passes its terminal value.
- A pulse is never longer than PULSE_CLKS and always ends at exactly that length.
- A service write blocks a rising pulse on the next edge.
- An unarmed software-mode timer never fires.
- The arm flag never sets in the always-armed mode.

Only the bench scenarios show the timing seen at the ports. They sweep the service point across the whole window and check where each pulse lands. They also show that the arm, disarm and other-address writes have the effect the requirements state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        WDT_MODE_SOFT   = 1'b0,
        WDT_MODE_ALWAYS = 1'b1
    } wdt_mode_e;

    typedef struct packed {
        logic service;
        logic arm;
        logic disarm;
    } wdt_cmd_t;

    function automatic int unsigned clocks_per_ms(input int unsigned clk_hz);
        return (clk_hz < 1000) ? 1 : clk_hz / 1000;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned SVC_ADDR  = 'h1EF,
    parameter int unsigned CTRL_ADDR = 'h1EE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  wdt_mode_e         mode,
    input  logic              blocked,
    output wdt_cmd_t          cmd
);

    logic svc_hit;
    logic ctrl_hit;
    logic unused_upper_data;

    assign svc_hit  = wr && (addr == ADDR_W'(SVC_ADDR)) && !blocked;
    assign ctrl_hit = wr && (addr == ADDR_W'(CTRL_ADDR)) && !blocked
                      && (mode == WDT_MODE_SOFT);

    always_comb begin
        cmd         = '0;
        cmd.service = svc_hit;
        cmd.arm     = ctrl_hit && wdata[0];
        cmd.disarm  = ctrl_hit && !wdata[0];
    end

    generate
        if (DATA_W > 1) begin : g_wide
            assign unused_upper_data = ^wdata[DATA_W-1:1];
        end else begin : g_narrow
            assign unused_upper_data = 1'b0;
        end
    endgenerate

    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.service, cmd.arm, cmd.disarm}))
        else $error("decode produced two commands at once"); // R5

    AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        blocked |-> (cmd == '0))
        else $error("command accepted during pulse"); // R10

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
    import wdt_pkg::*;
#(
    parameter int unsigned DIV   = 1000,
    parameter int unsigned TICKS = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic expire
);

    localparam int unsigned MW    = width_for(TICKS);
    localparam int unsigned LIMIT = DIV * TICKS;
    localparam int unsigned LW    = width_for(LIMIT + 1);

    logic          tick;
    logic          hold;
    logic [MW-1:0] ms_q;
    logic          ms_last;

    assign hold = rst || clear || !run;

    generate
        if (DIV > 1) begin : g_prescale
            localparam int unsigned PW = width_for(DIV);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (hold) begin
                    pre_q <= '0;
                end else if (pre_q == PW'(DIV - 1)) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
            assign tick = run && (pre_q == PW'(DIV - 1));
        end else begin : g_direct
            assign tick = run;
        end
    endgenerate

    assign ms_last = (ms_q == MW'(TICKS - 1));

    always_ff @(posedge clk) begin
        if (hold) begin
            ms_q <= '0;
        end else if (tick) begin
            ms_q <= ms_last ? '0 : ms_q + 1'b1;
        end
    end

    assign expire = tick && ms_last && !clear;

    // Checker state: armed cycles since the last restart.
    logic [LW-1:0] elapsed_q;
    always_ff @(posedge clk) begin
        if (hold) begin
            elapsed_q <= '0;
        end else begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        expire |-> (elapsed_q == LW'(LIMIT - 1)))
        else $error("expiry not at the interval end"); // R11

    AST_MS_BOUND: assert property (@(posedge clk) disable iff (rst)
        ms_q <= MW'(TICKS - 1))
        else $error("millisecond count overran"); // R2

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
    import wdt_pkg::*;
#(
    parameter int unsigned PULSE_CLKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);

    localparam int unsigned CW = width_for(PULSE_CLKS);
    localparam int unsigned HW = width_for(PULSE_CLKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (active) begin
            if (cnt_q == CW'(PULSE_CLKS - 1)) begin
                active <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (fire) begin
            active <= 1'b1;
            cnt_q  <= '0;
        end
    end

    // Checker state: length of the current high run.
    logic [HW-1:0] hi_len_q;
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            hi_len_q <= '0;
        end else begin
            hi_len_q <= hi_len_q + 1'b1;
        end
    end

    AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
        active |-> (hi_len_q < HW'(PULSE_CLKS)))
        else $error("pulse too long"); // R8

    AST_PULSE_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> (hi_len_q == HW'(PULSE_CLKS)))
        else $error("pulse ended early"); // R8

endmodule

// File: rtl/strap_watchdog.sv
module strap_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 33_000_000,
    parameter int unsigned TIMEOUT_MS = 1500,
    parameter int unsigned PULSE_CLKS = 16,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SVC_ADDR   = 'h1EF,
    parameter int unsigned CTRL_ADDR  = 'h1EE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              mode_always,
    output logic              wdt_rst_out
);

    localparam int unsigned DIV = clocks_per_ms(CLK_HZ);

    wdt_mode_e mode;
    wdt_cmd_t  cmd;
    logic      sw_en_q;
    logic      armed;
    logic      pulse_on;
    logic      restart;
    logic      expire;

    assign mode = wdt_mode_e'(mode_always);

    wdt_bus_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SVC_ADDR (SVC_ADDR),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_decode (
        .clk    (clk),
        .rst    (rst),
        .wr     (io_wr),
        .addr   (io_addr),
        .wdata  (io_wdata),
        .mode   (mode),
        .blocked(pulse_on),
        .cmd    (cmd)
    );

    always_ff @(posedge clk) begin
        if (rst || pulse_on) begin
            sw_en_q <= 1'b0;
        end else if (cmd.arm) begin
            sw_en_q <= 1'b1;
        end else if (cmd.disarm) begin
            sw_en_q <= 1'b0;
        end
    end

    assign armed   = (mode == WDT_MODE_ALWAYS) || sw_en_q;
    assign restart = cmd.service || cmd.arm || cmd.disarm;

    wdt_timebase #(
        .DIV  (DIV),
        .TICKS(TIMEOUT_MS)
    ) u_timebase (
        .clk   (clk),
        .rst   (rst),
        .run   (armed && !pulse_on),
        .clear (restart),
        .expire(expire)
    );

    wdt_pulse #(
        .PULSE_CLKS(PULSE_CLKS)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (expire),
        .active(pulse_on)
    );

    assign wdt_rst_out = pulse_on;

    AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (rst)
        (io_wr && (io_addr == ADDR_W'(SVC_ADDR)) && !wdt_rst_out)
            |=> !$rose(wdt_rst_out))
        else $error("pulse despite service write"); // R9

    AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!mode_always && !sw_en_q && !wdt_rst_out) |=> !wdt_rst_out)
        else $error("unarmed timer fired"); // R4

    AST_ALWAYS_NO_ARM: assert property (@(posedge clk) disable iff (rst)
        (mode_always && !sw_en_q) |=> !sw_en_q)
        else $error("arm flag set in always mode"); // R7

endmodule

// File: tb/tb_strap_watchdog.sv
`timescale 1ns/1ps
module tb_strap_watchdog;

    localparam int CLK_HZ     = 4000;
    localparam int TIMEOUT_MS = 30;
    localparam int PULSE      = 5;
    localparam int LIMIT      = (CLK_HZ / 1000) * TIMEOUT_MS;
    localparam logic [15:0] SVC  = 16'h01EF;
    localparam logic [15:0] CTRL = 16'h01EE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        mode_always = 1'b1;
    logic        wdt_rst_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    strap_watchdog #(
        .CLK_HZ    (CLK_HZ),
        .TIMEOUT_MS(TIMEOUT_MS),
        .PULSE_CLKS(PULSE)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .io_wr      (io_wr),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .mode_always(mode_always),
        .wdt_rst_out(wdt_rst_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        if (n > 0) begin
            repeat (n) @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input bit m);
        rst = 1'b1;
        mode_always = m;
        step(3);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        io_wr = 1'b1;
        io_addr = a;
        io_wdata = d;
        step(1);
        io_wr = 1'b0;
    endtask

    task automatic expect_quiet(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (wdt_rst_out) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic expect_fire(input int n, input string req);
        expect_quiet(n - 1, req);
        step(1);
        check(wdt_rst_out == 1'b1, req, int'(wdt_rst_out), 1);
    endtask

    task automatic expect_pulse(input string req);
        int hi = 1;
        for (int i = 0; i < PULSE - 1; i++) begin
            step(1);
            if (wdt_rst_out) hi++;
        end
        check(hi == PULSE, req, hi, PULSE);
        step(1);
        check(wdt_rst_out == 1'b0, req, int'(wdt_rst_out), 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        // R1: output low out of reset
        check(wdt_rst_out == 1'b0, "R1", int'(wdt_rst_out), 0);

        // R2 / R11: always-armed timeout counted from reset
        expect_fire(LIMIT, "R2");
        expect_pulse("R8");
        expect_fire(LIMIT, "R11");
        expect_pulse("R8");

        // R3: service point swept over the whole window, data varied
        for (int k = 1; k <= LIMIT; k++) begin
            do_reset(1'b1);
            step(k - 1);
            do_write(SVC, 8'((k * 37) & 255));
            expect_fire(LIMIT, "R3");
            expect_pulse("R8");
        end

        // R9: service on the terminal edge wins
        do_reset(1'b1);
        step(LIMIT - 1);
        do_write(SVC, 8'hA5);
        check(wdt_rst_out == 1'b0, "R9", int'(wdt_rst_out), 0);
        expect_fire(LIMIT, "R9");
        expect_pulse("R8");

        // R10: other addresses have no effect
        do_reset(1'b1);
        step(10);
        do_write(16'h11EF, 8'h00);
        do_write(16'h01ED, 8'h00);
        do_write(16'h00EF, 8'h00);
        expect_fire(LIMIT - 13, "R10");
        // R10: writes during the pulse ignored
        do_write(SVC, 8'h00);
        do_write(CTRL, 8'h00);
        check(wdt_rst_out == 1'b1, "R10", int'(wdt_rst_out), 1);
        step(PULSE - 3);
        check(wdt_rst_out == 1'b1, "R10", int'(wdt_rst_out), 1);
        step(1);
        check(wdt_rst_out == 1'b0, "R10", int'(wdt_rst_out), 0);
        expect_fire(LIMIT, "R10");
        expect_pulse("R8");

        // R7: control writes ignored in always mode
        do_reset(1'b1);
        step(20);
        do_write(CTRL, 8'h01);
        do_write(CTRL, 8'h00);
        expect_fire(LIMIT - 22, "R7");
        // R1: reset during a pulse clears it
        do_reset(1'b1);
        check(wdt_rst_out == 1'b0, "R1", int'(wdt_rst_out), 0);

        // R4: software mode idle after reset
        do_reset(1'b0);
        expect_quiet(3 * LIMIT, "R4");
        do_write(CTRL, 8'hFE);
        expect_quiet(2 * LIMIT, "R6");
        do_write(SVC, 8'h11);
        expect_quiet(2 * LIMIT, "R4");

        // R5: arm write starts a full interval
        do_write(CTRL, 8'h01);
        expect_fire(LIMIT, "R5");
        expect_pulse("R8");
        expect_quiet(3 * LIMIT, "R8");

        // R6: disarm clears the count
        do_write(CTRL, 8'hFF);
        step(40);
        do_write(CTRL, 8'h00);
        expect_quiet(3 * LIMIT, "R6");
        do_write(CTRL, 8'h03);
        expect_fire(LIMIT, "R6");
        expect_pulse("R8");

        // R5: repeated arm write restarts the count
        do_write(CTRL, 8'h01);
        step(60);
        do_write(CTRL, 8'h01);
        expect_fire(LIMIT, "R5");
        expect_pulse("R8");

        // R10: arm write during the pulse is ignored
        do_write(CTRL, 8'h01);
        expect_fire(LIMIT, "R5");
        do_write(CTRL, 8'h01);
        step(PULSE - 2);
        check(wdt_rst_out == 1'b1, "R10", int'(wdt_rst_out), 1);
        step(1);
        check(wdt_rst_out == 1'b0, "R10", int'(wdt_rst_out), 0);
        expect_quiet(3 * LIMIT, "R10");

        // R3: services keep an armed software-mode timer quiet
        do_write(CTRL, 8'h01);
        for (int j = 0; j < 4; j++) begin
            expect_quiet(LIMIT - 10, "R3");
            do_write(SVC, 8'(j));
        end
        expect_fire(LIMIT, "R3");
        expect_pulse("R8");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule